// File: doc/BRIEF.md
# Test Access Port Target

This block is the device-side end of a serial test access port. A sixteen-state controller advances on every rising edge of the test clock and steers on the mode-select input. Its states decide when an instruction or data register is captured into a shift path, shifted through, held, or written back. The block holds a parameterised instruction register and three data registers: a one-bit pass-through register, a read-only identification register, and one writable user register. The core sees the user register's contents on a parallel output.

The host reaches the block serially. Data enters on the test-data input and is sampled on the rising edge of the test clock. The serial output changes on the falling edge and is enabled only while bits are being shifted. A host reads the user register with a data scan and writes the new value in the same scan. The identification register can be read at any time, but a value shifted into it never sticks.

Top module: `tap_port`

## Requirements
- R1: Five consecutive rising clock edges with mode-select high bring the controller to its reset state from every state. In that state the instruction register returns to the identification code (default 4'b0001).
- R2: In the idle state the controller stays put for as long as mode-select is low, and the serial output enable stays low.
- R3: Driving the active-low asynchronous reset input low forces the controller to its reset state, loads the identification instruction, clears the user register to zero and drops the output enable.
- R4: An instruction capture loads a fixed pattern whose two low bits are 01 and whose other bits are zero. For a 4-bit register, the bits shifted out least-significant first are therefore 1,0,0,0.
- R5: Each rising edge in a shift state moves one bit in from the serial input at the most-significant end of the selected path. The serial output presents the least-significant bit, changing on the falling edge. A mode-select pattern of 0,...,0,1 from the shift state shifts exactly as many bits as it has edges. The output enable is high only in the two shift states.
- R6: A data capture with the user register selected takes a snapshot of the current user value, and that snapshot is what the scan shifts out.
- R7: The user register (default 8 bits, instruction code 4'b0010) changes only in the data-update state, where it takes the value shifted in.
- R8: In either pause state the shift contents are held and the target register is not written. A scan that resumes from pause continues where it stopped.
- R9: An all-ones instruction selects the one-bit pass-through register. It captures 0, so a data scan returns a leading 0 followed by the serial input delayed by one bit.
- R10: Any instruction code other than the identification and user codes selects the pass-through register.
- R11: The identification register (default 32'h1A5C_30E7) captures its fixed value. A value shifted in while it is selected changes neither it nor the user register.
- R12: The instruction-update state copies the instruction shift path into the instruction register, and that value selects the data path for later scans.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdoEn | output | 1 | High while a shift state drives tdo |
| userOut | output | USER_W | Contents of the user register for the core |

## Verification
Every 4-bit mode-select prefix taken from idle is followed by five high bits. This reaches most controller states, and recovery is proven by reading back the identification code. A sweep over all sixteen instruction codes splits the identification path, the user path and the pass-through path by what a data scan returns: a fixed value, the previous write, or the input delayed by one. All 256 user values are written and read back, which shows that capture really is a snapshot of the old value. Separate scans pause part-way, write to the read-only register, and pull reset mid-scan, so that holding, ignoring and forced reset can each be told apart from a normal update.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    S_RESET, S_IDLE,
    S_DR_SEL, S_DR_CAP, S_DR_SHIFT, S_DR_EX1, S_DR_PAUSE, S_DR_EX2, S_DR_UPD,
    S_IR_SEL, S_IR_CAP, S_IR_SHIFT, S_IR_EX1, S_IR_PAUSE, S_IR_EX2, S_IR_UPD
  } tapState_t;

  typedef struct packed {
    logic resetLogic;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
  } tapStrobes_t;

  typedef enum logic [1:0] {
    SEL_BYPASS,
    SEL_ID,
    SEL_USER
  } drSel_t;

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tms,
  output tapStrobes_t str
);

  tapState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_RESET:    stateNext = tms ? S_RESET    : S_IDLE;
      S_IDLE:     stateNext = tms ? S_DR_SEL   : S_IDLE;
      S_DR_SEL:   stateNext = tms ? S_IR_SEL   : S_DR_CAP;
      S_DR_CAP:   stateNext = tms ? S_DR_EX1   : S_DR_SHIFT;
      S_DR_SHIFT: stateNext = tms ? S_DR_EX1   : S_DR_SHIFT;
      S_DR_EX1:   stateNext = tms ? S_DR_UPD   : S_DR_PAUSE;
      S_DR_PAUSE: stateNext = tms ? S_DR_EX2   : S_DR_PAUSE;
      S_DR_EX2:   stateNext = tms ? S_DR_UPD   : S_DR_SHIFT;
      S_DR_UPD:   stateNext = tms ? S_DR_SEL   : S_IDLE;
      S_IR_SEL:   stateNext = tms ? S_RESET    : S_IR_CAP;
      S_IR_CAP:   stateNext = tms ? S_IR_EX1   : S_IR_SHIFT;
      S_IR_SHIFT: stateNext = tms ? S_IR_EX1   : S_IR_SHIFT;
      S_IR_EX1:   stateNext = tms ? S_IR_UPD   : S_IR_PAUSE;
      S_IR_PAUSE: stateNext = tms ? S_IR_EX2   : S_IR_PAUSE;
      S_IR_EX2:   stateNext = tms ? S_IR_UPD   : S_IR_SHIFT;
      S_IR_UPD:   stateNext = tms ? S_DR_SEL   : S_IDLE;
      default:    stateNext = S_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= S_RESET;
    else        state <= stateNext;
  end

  always_comb begin
    str.resetLogic = (state == S_RESET);
    str.captureDr  = (state == S_DR_CAP);
    str.shiftDr    = (state == S_DR_SHIFT);
    str.updateDr   = (state == S_DR_UPD);
    str.captureIr  = (state == S_IR_CAP);
    str.shiftIr    = (state == S_IR_SHIFT);
    str.updateIr   = (state == S_IR_UPD);
  end

  // Checker counter: consecutive edges with mode-select high, saturating at 5.
  logic [2:0] highRun;
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              highRun <= '0;
    else if (!tms)           highRun <= '0;
    else if (highRun != 3'd5) highRun <= highRun + 3'd1;
  end

  assert_five_high_reset_R1: assert property (@(posedge tck) disable iff (!trstN)
    (highRun == 3'd5) |-> (state == S_RESET));

  assert_idle_hold_R2: assert property (@(posedge tck) disable iff (!trstN)
    (state == S_IDLE && !tms) |=> (state == S_IDLE));

  assert_single_action_R5: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({str.captureDr, str.shiftDr, str.updateDr,
              str.captureIr, str.shiftIr, str.updateIr, str.resetLogic}));

  assert_pause_leave_R8: assert property (@(posedge tck) disable iff (!trstN)
    (state == S_DR_PAUSE && !tms) |=> (state == S_DR_PAUSE));

endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import tap_pkg::*;
#(
  parameter int IR_W   = 4,
  parameter int ID_W   = 32,
  parameter int USER_W = 8,
  parameter logic [ID_W-1:0] ID_VAL    = 32'h1A5C_30E7,
  parameter logic [IR_W-1:0] ID_INSN   = 1,
  parameter logic [IR_W-1:0] USER_INSN = 2
)(
  input  logic              tck,
  input  logic              trstN,
  input  logic              tdi,
  input  tapStrobes_t       str,
  output logic              tdo,
  output logic              tdoEn,
  output logic [USER_W-1:0] userOut
);

  localparam int DR_W = (ID_W > USER_W) ? ID_W : USER_W;
  localparam int LW   = (DR_W > 1) ? $clog2(DR_W) : 1;
  localparam logic [IR_W-1:0] IR_CAP = IR_W'(2'b01);

  logic [IR_W-1:0]   irShift, irReg;
  logic [DR_W-1:0]   drShift, shiftNext, captureVal;
  logic [USER_W-1:0] userReg;
  logic [LW-1:0]     lenM1;
  drSel_t            sel;

  // Instruction decode: unknown codes fall through to pass-through.
  always_comb begin
    if (irReg == ID_INSN)        sel = SEL_ID;
    else if (irReg == USER_INSN) sel = SEL_USER;
    else                         sel = SEL_BYPASS;
  end

  always_comb begin
    unique case (sel)
      SEL_ID:   begin lenM1 = LW'(ID_W - 1);   captureVal = DR_W'(ID_VAL);  end
      SEL_USER: begin lenM1 = LW'(USER_W - 1); captureVal = DR_W'(userReg); end
      default:  begin lenM1 = '0;              captureVal = '0;             end
    endcase
  end

  // Serial input enters at the top of the currently selected path length.
  for (genvar i = 0; i < DR_W; i++) begin : g_drBit
    if (i == DR_W - 1) begin : g_top
      assign shiftNext[i] = (lenM1 == LW'(i)) ? tdi : 1'b0;
    end else begin : g_mid
      assign shiftNext[i] = (lenM1 == LW'(i)) ? tdi : drShift[i+1];
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)             drShift <= '0;
    else if (str.captureDr) drShift <= captureVal;
    else if (str.shiftDr)   drShift <= shiftNext;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)             irShift <= '0;
    else if (str.captureIr) irShift <= IR_CAP;
    else if (str.shiftIr) begin
      if (IR_W > 1) irShift <= {tdi, irShift[IR_W-1:1]};
      else          irShift <= IR_W'(tdi);
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              irReg <= ID_INSN;
    else if (str.resetLogic) irReg <= ID_INSN;
    else if (str.updateIr)   irReg <= irShift;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                                userReg <= '0;
    else if (str.updateDr && sel == SEL_USER)  userReg <= drShift[USER_W-1:0];
  end

  // Output path is retimed to the falling edge.
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= str.shiftIr ? irShift[0] : drShift[0];
      tdoEn <= str.shiftIr | str.shiftDr;
    end
  end

  assign userOut = userReg;

  assert_ir_capture_R4: assert property (@(posedge tck) disable iff (!trstN)
    str.captureIr |=> (irShift[1:0] == 2'b01));

  assert_user_only_on_update_R7: assert property (@(posedge tck) disable iff (!trstN)
    !str.updateDr |=> $stable(userReg));

  assert_bypass_capture_R9: assert property (@(posedge tck) disable iff (!trstN)
    (str.captureDr && sel == SEL_BYPASS) |=> (drShift[0] == 1'b0));

  assert_id_readonly_R11: assert property (@(posedge tck) disable iff (!trstN)
    (str.updateDr && sel == SEL_ID) |=> $stable(userReg));

  assert_reset_insn_R12: assert property (@(posedge tck) disable iff (!trstN)
    str.resetLogic |=> (irReg == ID_INSN));

  assert_pause_hold_R8: assert property (@(posedge tck) disable iff (!trstN)
    (!str.captureDr && !str.shiftDr) |=> $stable(drShift));

endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int IR_W   = 4,
  parameter int ID_W   = 32,
  parameter int USER_W = 8,
  parameter logic [ID_W-1:0] ID_VAL    = 32'h1A5C_30E7,
  parameter logic [IR_W-1:0] ID_INSN   = 1,
  parameter logic [IR_W-1:0] USER_INSN = 2
)(
  input  logic              tck,
  input  logic              trstN,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdoEn,
  output logic [USER_W-1:0] userOut
);

  tapStrobes_t str;

  tap_ctrl ctrl_i (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .str   (str)
  );

  tap_datapath #(
    .IR_W      (IR_W),
    .ID_W      (ID_W),
    .USER_W    (USER_W),
    .ID_VAL    (ID_VAL),
    .ID_INSN   (ID_INSN),
    .USER_INSN (USER_INSN)
  ) dp_i (
    .tck     (tck),
    .trstN   (trstN),
    .tdi     (tdi),
    .str     (str),
    .tdo     (tdo),
    .tdoEn   (tdoEn),
    .userOut (userOut)
  );

endmodule

// File: tb/tap_port_tb.sv
module tap_port_tb_top;

  localparam logic [31:0] ID_VAL = 32'h1A5C_30E7;
  localparam logic [3:0]  ID_CODE = 4'b0001;
  localparam logic [3:0]  USER_CODE = 4'b0010;

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdoEn;
  logic [7:0] userOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [7:0] expUser = 8'h00;

  always #10 tck = ~tck;

  tap_port dut_i (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdoEn(tdoEn), .userOut(userOut)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck);
    #2;
    o = tdo;
    oe = tdoEn;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic go(input logic m);
    logic o, oe;
    step(m, 1'b0, o, oe);
  endtask

  // From idle: data scan of n bits, back to idle.
  task automatic scanDr(input logic [31:0] din, input int n, output logic [31:0] dout);
    logic o, oe;
    logic enOk = 1'b1;
    dout = '0;
    go(1); go(0); go(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, oe);
      dout[i] = o;
      if (oe !== 1'b1) enOk = 1'b0;
    end
    go(1); go(0);
    check(enOk, "R5 enable during data shift", {31'b0, enOk}, 32'h1);
  endtask

  task automatic scanIr(input logic [3:0] din, output logic [3:0] dout);
    logic o, oe;
    dout = '0;
    go(1); go(1); go(0); go(0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, din[i], o, oe);
      dout[i] = o;
    end
    go(1); go(0);
  endtask

  task automatic loadIr(input logic [3:0] code);
    logic [3:0] cap;
    scanIr(code, cap);
    check(cap == 4'b0001, "R4 instruction capture pattern", {28'b0, cap}, 32'h1);
  endtask

  initial begin
    forever begin
      @(posedge tck);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] dout;
    logic o, oe;
    logic stableOk;

    repeat (3) @(posedge tck);
    @(negedge tck);
    trstN = 1'b1;

    // R3: reset state at the ports
    check(userOut == 8'h00, "R3 user cleared", {24'b0, userOut}, 32'h0);
    check(tdoEn == 1'b0, "R3 enable low", {31'b0, tdoEn}, 32'h0);
    go(0);
    scanDr(32'hFFFF_FFFF, 32, dout);
    check(dout == ID_VAL, "R12 reset selects identification", dout, ID_VAL);

    // R2: idle holds while mode-select low
    stableOk = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 1'b1, o, oe);
      if (oe !== 1'b0) stableOk = 1'b0;
    end
    check(stableOk, "R2 enable low in idle", {31'b0, stableOk}, 32'h1);
    scanDr(32'h0, 32, dout);
    check(dout == ID_VAL, "R2 still in idle after low run", dout, ID_VAL);

    // R11: write to identification ignored
    scanDr(32'h0BAD_F00D, 32, dout);
    check(dout == ID_VAL, "R11 identification capture", dout, ID_VAL);
    scanDr(32'h0, 32, dout);
    check(dout == ID_VAL, "R11 identification unchanged", dout, ID_VAL);
    check(userOut == expUser, "R11 user unaffected", {24'b0, userOut}, {24'b0, expUser});

    // R6/R7/R12: sweep all user values, read back previous
    loadIr(USER_CODE);
    for (int v = 0; v < 256; v++) begin
      scanDr({24'b0, 8'(v)}, 8, dout);
      check(dout[7:0] == expUser, "R6 snapshot of previous value", dout, {24'b0, expUser});
      expUser = 8'(v);
      check(userOut == expUser, "R7 user written on update", {24'b0, userOut}, {24'b0, expUser});
    end

    // R9/R10: sweep all instruction codes
    for (int c = 0; c < 16; c++) begin
      logic [7:0] din;
      logic [7:0] exp;
      din = 8'hC6 ^ 8'(c * 17);
      loadIr(4'(c));
      scanDr({24'b0, din}, 8, dout);
      if (4'(c) == ID_CODE) exp = ID_VAL[7:0];
      else if (4'(c) == USER_CODE) exp = expUser;
      else exp = {din[6:0], 1'b0};
      if (4'(c) == 4'hF)
        check(dout[7:0] == exp, "R9 all-ones pass-through", dout, {24'b0, exp});
      else if (4'(c) == ID_CODE || 4'(c) == USER_CODE)
        check(dout[7:0] == exp, "R12 selected path", dout, {24'b0, exp});
      else
        check(dout[7:0] == exp, "R10 unknown code pass-through", dout, {24'b0, exp});
      if (4'(c) == USER_CODE) expUser = din;
      check(userOut == expUser, "R7 user only via user path", {24'b0, userOut}, {24'b0, expUser});
    end

    // R8: pause mid-scan
    loadIr(USER_CODE);
    begin
      logic [7:0] din = 8'h5B;
      logic [7:0] rd = '0;
      go(1); go(0); go(0);
      for (int i = 0; i < 3; i++) begin
        step(i == 2, din[i], o, oe);
        rd[i] = o;
      end
      go(0);
      stableOk = 1'b1;
      for (int i = 0; i < 6; i++) begin
        step(1'b0, 1'(i), o, oe);
        if (userOut !== expUser || oe !== 1'b0) stableOk = 1'b0;
      end
      check(stableOk, "R8 no update and no drive in pause", {31'b0, stableOk}, 32'h1);
      go(1); go(0);
      for (int i = 3; i < 8; i++) begin
        step(i == 7, din[i], o, oe);
        rd[i] = o;
      end
      go(1); go(0);
      check(rd == expUser, "R8 resumed scan continues", {24'b0, rd}, {24'b0, expUser});
      expUser = din;
      check(userOut == expUser, "R8 value after resumed scan", {24'b0, userOut}, {24'b0, expUser});
    end

    // R1: every 4-bit prefix from idle then five highs
    for (int p = 0; p < 16; p++) begin
      loadIr(USER_CODE);
      for (int j = 0; j < 4; j++) go(p[j]);
      repeat (5) go(1);
      go(0);
      scanDr(32'h0, 32, dout);
      check(dout == ID_VAL, "R1 five highs reach reset", dout, ID_VAL);
    end

    // R3: reset mid-scan
    loadIr(USER_CODE);
    scanDr(32'h0000_00A7, 8, dout);
    expUser = 8'hA7;
    go(1); go(0); go(0); go(0);
    @(negedge tck);
    trstN = 1'b0;
    #3;
    check(userOut == 8'h00, "R3 user cleared mid-scan", {24'b0, userOut}, 32'h0);
    check(tdoEn == 1'b0, "R3 enable dropped", {31'b0, tdoEn}, 32'h0);
    @(posedge tck);
    @(negedge tck);
    trstN = 1'b1;
    tms = 1'b0;
    go(0);
    scanDr(32'h0, 32, dout);
    check(dout == ID_VAL, "R3 identification after reset", dout, ID_VAL);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule